// File: doc/BRIEF.md
# Codec Command/Response Ring Engine

This block carries codec verbs between software-visible rings and the per-frame slots of a serial audio link. Software writes command words into an internal outbound ring and advances a write pointer. On each frame tick the engine sends at most one command in the outgoing command slot. It then records which codecs owe a reply. Replies that arrive in the per-codec response slots are filed into an internal inbound ring. Each filed entry carries a tag that holds the codec index and a flag marking the reply as unsolicited.

A command names its target in its top four bits. The value 15 addresses every attached codec, and the command is complete only once each of them has replied. No further command leaves while any reply is still owed. Unsolicited replies are filed like any other reply and do not count as answers.

A one-deep immediate path lets firmware send a single command and poll for its answer without touching either ring. While that path is busy it wins the next free slot, and the answer it collects goes to a holding register rather than to the ring. Both rings hold 256 entries, and their pointers wrap modulo that size.

Top module: `codec_ring_engine`

## Requirements
- R1: After reset, `slot_valid`, `cmd_rp`, `rsp_wp`, `outstanding`, `imm_busy`, `imm_valid` and `overrun` are all zero.
- R2: On a `frame_tick` edge where the ring holds a command (`cmd_rp != cmd_wp`) and the engine may issue, the word at `cmd_rp` is driven on `slot_cmd`. `slot_valid` is high for the following cycle, and `cmd_rp` advances by one modulo 256. When `cmd_rp == cmd_wp` no slot is sent.
- R3: When a command is sent, `outstanding` is loaded from its bits [31:28]. The value 15 sets all NCODEC bits, a value below NCODEC sets that codec's bit, and any other value sets none.
- R4: No command is sent while `outstanding` is nonzero or received replies are still waiting to be filed.
- R5: Replies are latched on a `frame_tick` edge from `link_rsp_valid`. They are filed one per cycle, lowest codec index first, starting one edge after the tick. Each entry has data in bits [31:0], the codec index in bit 32 and the unsolicited flag in bit 33, and `rsp_wp` advances by one per entry.
- R6: A solicited reply clears its codec's `outstanding` bit when it is filed. An unsolicited reply is filed with bit 33 set and leaves `outstanding` unchanged.
- R7: If the inbound ring is full (`rsp_wp + 1 == rsp_rp` modulo 256), the reply is dropped, `rsp_wp` holds, and `overrun` sets. `overrun` stays set until `overrun_clr` is pulsed.
- R8: `imm_go` while idle latches `imm_cmd` and raises `imm_busy`, and `imm_go` while busy is ignored. The latched word takes the next slot ahead of any ring command and leaves `cmd_rp` unchanged.
- R9: Solicited replies to the immediate command go to `imm_resp` and not to the ring. When none remain owed, `imm_busy` falls and `imm_valid` rises, and `imm_valid` stays high until `imm_valid_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr_en | input | 1 | Write strobe into the outbound ring |
| cmd_wr_addr | input | 8 | Outbound ring write address |
| cmd_wr_data | input | 32 | Outbound ring write data |
| cmd_wp | input | 8 | Software write pointer of the outbound ring |
| cmd_rp | output | 8 | Engine read pointer of the outbound ring |
| rsp_rd_addr | input | 8 | Inbound ring read address |
| rsp_rd_data | output | 34 | Inbound ring entry at `rsp_rd_addr` (tag and data) |
| rsp_rp | input | 8 | Software read pointer of the inbound ring |
| rsp_wp | output | 8 | Engine write pointer of the inbound ring |
| overrun | output | 1 | Sticky flag for a dropped reply |
| overrun_clr | input | 1 | Clears `overrun` |
| imm_cmd | input | 32 | Immediate command word |
| imm_go | input | 1 | Starts an immediate command |
| imm_busy | output | 1 | Immediate command in progress |
| imm_resp | output | 32 | Last immediate reply |
| imm_valid | output | 1 | Immediate reply complete |
| imm_valid_clr | input | 1 | Clears `imm_valid` |
| frame_tick | input | 1 | One-cycle frame boundary pulse |
| slot_valid | output | 1 | Command slot carries a command |
| slot_cmd | output | 32 | Command slot word |
| link_rsp_valid | input | 2 | Per-codec reply present in this frame |
| link_rsp_unsol | input | 2 | Per-codec unsolicited marker |
| link_rsp_data | input | 64 | Per-codec reply words, codec 0 in the low half |
| outstanding | output | 2 | Codecs that still owe a reply |

## Verification
The bench drives and samples on falling edges. It counts every register between a stimulus and the result it expects.
- A command pushed before a tick shows on `slot_cmd` and `cmd_rp` at the falling edge just after that tick edge.
- A reply latched on a tick edge has not yet moved `rsp_wp` at the next falling edge. It moves one step per cycle after that, and the bench checks this cycle by cycle for a broadcast.
- Immediate completion lands on the second edge after the tick that carried the answer.
- The remaining checks wait three cycles after a reply tick, which is past every filing and completion. Ring entries are read through the combinational read port.

// File: rtl/codec_ring_engine.sv
module codec_ring_engine #(
  parameter int NCODEC = 2,
  parameter int AW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_wr_en,
  input  logic [AW-1:0]        cmd_wr_addr,
  input  logic [31:0]          cmd_wr_data,
  input  logic [AW-1:0]        cmd_wp,
  output logic [AW-1:0]        cmd_rp,
  input  logic [AW-1:0]        rsp_rd_addr,
  output logic [32+(NCODEC>1 ? $clog2(NCODEC) : 1):0] rsp_rd_data,
  input  logic [AW-1:0]        rsp_rp,
  output logic [AW-1:0]        rsp_wp,
  output logic                 overrun,
  input  logic                 overrun_clr,
  input  logic [31:0]          imm_cmd,
  input  logic                 imm_go,
  output logic                 imm_busy,
  output logic [31:0]          imm_resp,
  output logic                 imm_valid,
  input  logic                 imm_valid_clr,
  input  logic                 frame_tick,
  output logic                 slot_valid,
  output logic [31:0]          slot_cmd,
  input  logic [NCODEC-1:0]    link_rsp_valid,
  input  logic [NCODEC-1:0]    link_rsp_unsol,
  input  logic [NCODEC*32-1:0] link_rsp_data,
  output logic [NCODEC-1:0]    outstanding
);
  localparam int DEPTH = 1 << AW;
  localparam int CIW   = NCODEC > 1 ? $clog2(NCODEC) : 1;
  localparam int EW    = 33 + CIW;

  logic [31:0]       cmd_mem [DEPTH];
  logic [EW-1:0]     rsp_mem [DEPTH];
  logic [NCODEC-1:0] hold_v, hold_u;
  logic [31:0]       hold_d [NCODEC];
  logic              imm_sent;
  logic [31:0]       imm_q;

  logic [CIW-1:0]    sel;
  logic [NCODEC-1:0] exp_mask;
  logic              found, imm_pend, issue, rsp_full, to_imm;
  logic [31:0]       next_word;

  assign found     = |hold_v;
  assign imm_pend  = imm_busy & ~imm_sent;
  assign issue     = frame_tick && outstanding == '0 && !found && !imm_sent &&
                     (imm_pend || cmd_rp != cmd_wp);
  assign next_word = imm_pend ? imm_q : cmd_mem[cmd_rp];
  assign rsp_full  = AW'(rsp_wp + 1'b1) == rsp_rp;
  assign to_imm    = ~hold_u[sel] & imm_sent;
  assign rsp_rd_data = rsp_mem[rsp_rd_addr];

  always_comb begin
    sel = '0;
    for (int i = NCODEC - 1; i >= 0; i--)
      if (hold_v[i]) sel = CIW'(i);
  end

  always_comb begin
    exp_mask = '0;
    if (next_word[31:28] == 4'hF) exp_mask = '1;
    else
      for (int i = 0; i < NCODEC; i++)
        if (next_word[31:28] == 4'(i)) exp_mask[i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (cmd_wr_en) cmd_mem[cmd_wr_addr] <= cmd_wr_data;
    if (found && !to_imm && !rsp_full)
      rsp_mem[rsp_wp] <= {hold_u[sel], sel, hold_d[sel]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_rp      <= '0;
      rsp_wp      <= '0;
      overrun     <= 1'b0;
      outstanding <= '0;
      hold_v      <= '0;
      hold_u      <= '0;
      for (int i = 0; i < NCODEC; i++) hold_d[i] <= '0;
      slot_valid  <= 1'b0;
      slot_cmd    <= '0;
      imm_busy    <= 1'b0;
      imm_sent    <= 1'b0;
      imm_valid   <= 1'b0;
      imm_q       <= '0;
      imm_resp    <= '0;
    end else begin
      slot_valid <= issue;
      if (issue) begin
        slot_cmd    <= next_word;
        outstanding <= exp_mask;
        if (imm_pend) imm_sent <= 1'b1;
        else          cmd_rp   <= cmd_rp + 1'b1;
      end

      if (overrun_clr) overrun <= 1'b0;
      if (found) begin
        hold_v[sel] <= 1'b0;
        if (!hold_u[sel]) outstanding[sel] <= 1'b0;
        if (to_imm)        imm_resp <= hold_d[sel];
        else if (rsp_full) overrun  <= 1'b1;
        else               rsp_wp   <= rsp_wp + 1'b1;
      end
      if (frame_tick)
        for (int i = 0; i < NCODEC; i++)
          if (link_rsp_valid[i]) begin
            hold_v[i] <= 1'b1;
            hold_u[i] <= link_rsp_unsol[i];
            hold_d[i] <= link_rsp_data[i*32 +: 32];
          end

      if (imm_valid_clr) imm_valid <= 1'b0;
      if (imm_go && !imm_busy) begin
        imm_busy  <= 1'b1;
        imm_q     <= imm_cmd;
        imm_valid <= 1'b0;
      end
      if (imm_sent && outstanding == '0 && !found) begin
        imm_busy  <= 1'b0;
        imm_sent  <= 1'b0;
        imm_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/codec_ring_engine_chk.sv
module codec_ring_engine_chk #(
  parameter int NCODEC = 2,
  parameter int AW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_tick,
  input logic              slot_valid,
  input logic [AW-1:0]     cmd_rp,
  input logic [AW-1:0]     rsp_wp,
  input logic              overrun,
  input logic              imm_busy,
  input logic              imm_valid,
  input logic [NCODEC-1:0] outstanding
);
  AST_SLOT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid |-> $past(frame_tick)); // R2
  AST_RP_MOVES_WITH_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rp != $past(cmd_rp)) |-> slot_valid); // R2
  AST_NO_ISSUE_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid |-> $past(outstanding) == '0); // R4
  AST_DROP_HOLDS_WP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $stable(rsp_wp)); // R7
  AST_IMM_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(imm_busy) |-> imm_valid); // R9
endmodule

bind codec_ring_engine codec_ring_engine_chk #(.NCODEC(NCODEC), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .slot_valid(slot_valid),
  .cmd_rp(cmd_rp), .rsp_wp(rsp_wp), .overrun(overrun), .imm_busy(imm_busy),
  .imm_valid(imm_valid), .outstanding(outstanding));

// File: tb/test_codec_ring_engine.sv
`timescale 1ns/1ps
module test_codec_ring_engine;
  logic clk = 0, rst_n = 0;
  logic cmd_wr_en = 0; logic [7:0] cmd_wr_addr = 0; logic [31:0] cmd_wr_data = 0;
  logic [7:0] cmd_wp = 0, cmd_rp, rsp_rd_addr = 0, rsp_rp = 0, rsp_wp;
  logic [33:0] rsp_rd_data;
  logic overrun, overrun_clr = 0, imm_go = 0, imm_busy, imm_valid, imm_valid_clr = 0;
  logic [31:0] imm_cmd = 0, imm_resp, slot_cmd;
  logic frame_tick = 0, slot_valid;
  logic [1:0] link_rsp_valid = 0, link_rsp_unsol = 0, outstanding;
  logic [63:0] link_rsp_data = 0;
  int errors = 0, checks = 0;
  logic [7:0] wr_ptr = 0, exp_wp = 0, rp_save;

  always #2.5 clk = ~clk;

  codec_ring_engine i_codec_ring_engine (.*);

  localparam logic [31:0] V_CMD [6] = '{32'h0A1B2C3D, 32'h1F000701, 32'hF0000F00,
                                        32'h0C000033, 32'h12004455, 32'h70001234};
  localparam logic [1:0]  V_EXP [6] = '{2'b01, 2'b10, 2'b11, 2'b01, 2'b10, 2'b00};
  localparam logic [1:0]  V_VAL [6] = '{2'b01, 2'b10, 2'b11, 2'b11, 2'b11, 2'b00};
  localparam logic [1:0]  V_UNS [6] = '{2'b00, 2'b00, 2'b00, 2'b10, 2'b01, 2'b00};

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [31:0] w);
    cmd_wr_en = 1; cmd_wr_addr = wr_ptr; cmd_wr_data = w;
    @(negedge clk);
    cmd_wr_en = 0; wr_ptr++; cmd_wp = wr_ptr;
  endtask

  task automatic tick(logic [1:0] v, logic [1:0] u, logic [31:0] d0, logic [31:0] d1);
    frame_tick = 1; link_rsp_valid = v; link_rsp_unsol = u; link_rsp_data = {d1, d0};
    @(negedge clk);
    frame_tick = 0; link_rsp_valid = 0; link_rsp_unsol = 0;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_entry(string req, logic [7:0] a, logic [33:0] exp);
    rsp_rd_addr = a; #0.5;
    chk(req, 64'(rsp_rd_data), 64'(exp));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 slot_valid", 64'(slot_valid), 0);
    chk("R1 pointers", {cmd_rp, rsp_wp}, 0);
    chk("R1 flags", {outstanding, imm_busy, imm_valid, overrun}, 0);
    rst_n = 1;
    step(1);

    tick(0, 0, 0, 0);
    chk("R2 empty ring sends nothing", {slot_valid, cmd_rp}, 0);

    for (int i = 0; i < 6; i++) begin
      logic [31:0] d0, d1;
      d0 = V_CMD[i] ^ 32'h5A5A0000; d1 = ~V_CMD[i];
      push(V_CMD[i]);
      tick(0, 0, 0, 0);
      chk("R2 slot word", {slot_valid, slot_cmd}, {1'b1, V_CMD[i]});
      chk("R2 read pointer", 64'(cmd_rp), 64'(wr_ptr));
      chk("R3 outstanding mask", 64'(outstanding), 64'(V_EXP[i]));
      tick(V_VAL[i], V_UNS[i], d0, d1);
      step(3);
      if (V_VAL[i][0]) begin chk_entry("R5 entry codec0", exp_wp, {V_UNS[i][0], 1'b0, d0}); exp_wp++; end
      if (V_VAL[i][1]) begin chk_entry("R5 entry codec1", exp_wp, {V_UNS[i][1], 1'b1, d1}); exp_wp++; end
      chk("R5 rsp_wp", 64'(rsp_wp), 64'(exp_wp));
      chk("R6 outstanding after replies", 64'(outstanding), 64'(V_EXP[i] & ~(V_VAL[i] & ~V_UNS[i])));
    end

    push(32'h000000AA);
    tick(0, 0, 0, 0);
    rp_save = cmd_rp;
    push(32'h000000BB);
    tick(0, 0, 0, 0);
    chk("R4 held while owed", {slot_valid, cmd_rp}, {1'b0, rp_save});
    tick(2'b01, 0, 32'h11110000, 0);
    step(3); exp_wp++;
    tick(0, 0, 0, 0);
    chk("R4 sent after reply", {slot_valid, slot_cmd}, {1'b1, 32'h000000BB});
    tick(2'b01, 0, 32'h22220000, 0);
    step(3); exp_wp++;

    push(32'hF00000C0);
    tick(0, 0, 0, 0);
    tick(2'b11, 0, 32'h33330000, 32'h44440000);
    chk("R5 no write on latch edge", 64'(rsp_wp), 64'(exp_wp));
    step(1);
    chk("R5 first filed", {outstanding, rsp_wp}, {2'b10, 8'(exp_wp + 1)});
    step(1);
    chk("R5 second filed", {outstanding, rsp_wp}, {2'b00, 8'(exp_wp + 2)});
    chk_entry("R5 low codec first", exp_wp, {2'b00, 32'h33330000});
    exp_wp += 2;

    tick(2'b01, 2'b01, 32'h55550000, 0);
    step(3);
    chk_entry("R6 unsolicited tag", exp_wp, {2'b10, 32'h55550000});
    exp_wp++;
    chk("R6 outstanding untouched", {outstanding, rsp_wp}, {2'b00, exp_wp});

    rsp_rp = exp_wp + 1;
    tick(2'b01, 2'b01, 32'h66660000, 0);
    step(3);
    chk("R7 dropped when full", {overrun, rsp_wp}, {1'b1, exp_wp});
    rsp_rp = 0;
    tick(2'b01, 2'b01, 32'h77770000, 0);
    step(3);
    chk_entry("R7 later reply filed", exp_wp, {2'b10, 32'h77770000});
    exp_wp++;
    chk("R7 overrun sticky", {overrun, rsp_wp}, {1'b1, exp_wp});
    overrun_clr = 1; step(1); overrun_clr = 0;
    chk("R7 overrun cleared", 64'(overrun), 0);

    push(32'h000000CC);
    rp_save = cmd_rp;
    imm_cmd = 32'h10000ABC; imm_go = 1; step(1); imm_go = 0;
    chk("R8 busy set", {imm_busy, imm_valid}, 2'b10);
    imm_cmd = 32'h1FFFFFFF; imm_go = 1; step(1); imm_go = 0;
    tick(0, 0, 0, 0);
    chk("R8 immediate wins slot", {slot_valid, slot_cmd}, {1'b1, 32'h10000ABC});
    chk("R8 ring pointer held", 64'(cmd_rp), 64'(rp_save));
    tick(2'b10, 0, 0, 32'hFACE0001);
    step(1);
    chk("R9 still busy one edge after latch", {imm_busy, imm_valid}, 2'b10);
    step(1);
    chk("R9 done", {imm_busy, imm_valid, imm_resp}, {2'b01, 32'hFACE0001});
    chk("R9 ring untouched", 64'(rsp_wp), 64'(exp_wp));
    tick(0, 0, 0, 0);
    chk("R8 ring command follows", {slot_valid, slot_cmd}, {1'b1, 32'h000000CC});
    tick(2'b01, 0, 32'h88880000, 0);
    step(3); exp_wp++;
    chk("R9 valid held", 64'(imm_valid), 1);
    imm_valid_clr = 1; step(1); imm_valid_clr = 0;
    chk("R9 valid cleared", {imm_valid, imm_busy, outstanding}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule